// File: doc/BRIEF.md
# Windowed MMIO Address Decoder

This block sits between a host address bus and a downstream memory-mapped target. It watches host addresses and decides whether each one falls inside a memory window that software has opened. The top 256 MB of a 32-bit address space is split into 32 fixed slices of 8 MB each. Slice k begins at `0xF0000000 + k * 0x800000`, so address bits 27:23 name the slice.

Software opens slices by writing a 32-bit enable mask. Bit k of the mask opens slice k. When two neighbouring bits are both set, their slices join with no gap. Software can therefore build one larger continuous region by setting a run of adjacent bits.

Every valid request gives one registered result one clock later. The result carries a hit flag, the slice index, and a forwarded address. Port I/O traffic and the data path are handled elsewhere, and this mask has no effect on them.

Top module: `mmio_window_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid`, `out_hit`, `out_win` and `out_addr` are all zero. The enable mask resets to zero, so no address can hit until software writes the mask.
- R2: A write with `cfg_we` high and `cfg_addr` equal to `0x060` loads `cfg_wdata` into the enable mask. The new mask applies to requests sampled on the clock edges after the write edge. A request sampled on the same edge as the write is decoded with the old mask.
- R3: A write to any `cfg_addr` other than `0x060` leaves the enable mask unchanged.
- R4: The window index is request address bits 27:23. Slice k covers `0xF0000000 | (k << 23)` up to that base plus `0x7FFFFF`, and both end bytes report index k. The index is reported for every valid request, whether it hits or not.
- R5: A valid request hits only when address bits 31:28 are all ones and mask bit [addr 27:23] is set.
- R6: An address below `0xF0000000` never hits, whatever the mask holds.
- R7: `out_valid` goes high exactly one cycle after a request is sampled with `req_valid` high. It is low in any cycle that follows a sample with `req_valid` low, and `out_hit` is low in that cycle too.
- R8: On a hit, `out_addr` equals the request address unchanged. On a miss, `out_addr` is zero.
- R9: When adjacent mask bits k and k+1 are both set, the last byte of slice k and the first byte of slice k+1 both hit. They form one continuous range.
- R10: With an all-zero mask, no address hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Host request address valid |
| req_addr | input | 32 | Host request address |
| out_valid | output | 1 | Decode result valid, one cycle after request |
| out_hit | output | 1 | Request falls in an enabled window |
| out_win | output | 5 | Window index (address bits 27:23) |
| out_addr | output | 32 | Forwarded address on hit, zero on miss |

## Verification
Each decode result appears one clock after its request is sampled. The bench drives a request on a falling edge and reads the outputs on the next falling edge, after exactly one rising edge. A mask write takes effect on its rising edge, so the first request that sees the new mask is the one sampled on the following edge. One case issues a write and a request on the same edge and expects the old mask to apply. The sweeps cover every window start and end byte under several masks, and each expected value is computed from the address bits and the bench's own copy of the mask.

// File: rtl/mmiodec_pkg.sv
package mmiodec_pkg;

    localparam int ADDR_W     = 32;
    localparam int WIN_SHIFT  = 23;
    localparam int IDX_W      = 5;
    localparam int NUM_WIN    = 1 << IDX_W;
    localparam int PFX_W      = ADDR_W - WIN_SHIFT - IDX_W;
    localparam int CFG_AW     = 12;
    localparam logic [CFG_AW-1:0] ENABLE_OFS = 12'h060;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [NUM_WIN-1:0] mask_t;
    typedef logic [CFG_AW-1:0]  cfg_addr_t;

    typedef struct packed {
        logic  valid;
        logic  hit;
        idx_t  idx;
        addr_t addr;
    } dec_res_t;

    function automatic idx_t win_index(input addr_t a);
        return a[WIN_SHIFT +: IDX_W];
    endfunction

    function automatic logic in_aperture(input addr_t a);
        return &a[ADDR_W-1 -: PFX_W];
    endfunction

    function automatic logic [ADDR_W-WIN_SHIFT-1:0] win_tag(input idx_t i);
        return {{PFX_W{1'b1}}, i};
    endfunction

endpackage

// File: rtl/mmio_win_enable_reg.sv
module mmio_win_enable_reg
    import mmiodec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  cfg_addr_t addr,
    input  mask_t     wdata,
    output mask_t     mask_q
);

    logic sel;

    always_comb begin
        sel = we && (addr == ENABLE_OFS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (sel) begin
            mask_q <= wdata;
        end
    end

endmodule

// File: rtl/mmio_win_match.sv
module mmio_win_match
    import mmiodec_pkg::*;
(
    input  logic     valid,
    input  addr_t    addr,
    input  mask_t    mask,
    output dec_res_t res
);

    localparam int TAG_W = ADDR_W - WIN_SHIFT;

    logic [NUM_WIN-1:0] lane_hit;
    logic [TAG_W-1:0]   tag;

    always_comb begin
        tag = addr[ADDR_W-1:WIN_SHIFT];
    end

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_lane
        always_comb begin
            lane_hit[k] = mask[k] && (tag == win_tag(idx_t'(k)));
        end
    end

    logic any_hit;

    always_comb begin
        any_hit = valid && in_aperture(addr) && (|lane_hit);
    end

    always_comb begin
        res       = '0;
        res.valid = valid;
        res.hit   = any_hit;
        res.idx   = valid ? win_index(addr) : '0;
        res.addr  = any_hit ? addr : '0;
    end

endmodule

// File: rtl/mmio_win_out_reg.sv
module mmio_win_out_reg
    import mmiodec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dec_res_t d,
    output dec_res_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
    import mmiodec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [11:0] cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        out_valid,
    output logic        out_hit,
    output logic [4:0]  out_win,
    output logic [31:0] out_addr
);

    mask_t    en_mask;
    dec_res_t dec_d;
    dec_res_t dec_q;

    mmio_win_enable_reg u_en (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .mask_q (en_mask)
    );

    mmio_win_match u_match (
        .valid (req_valid),
        .addr  (req_addr),
        .mask  (en_mask),
        .res   (dec_d)
    );

    mmio_win_out_reg u_out (
        .clk (clk),
        .rst (rst),
        .d   (dec_d),
        .q   (dec_q)
    );

    always_comb begin
        out_valid = dec_q.valid;
        out_hit   = dec_q.hit;
        out_win   = dec_q.idx;
        out_addr  = dec_q.addr;
    end

endmodule

// File: rtl/mmio_window_decoder_chk.sv
module mmio_window_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [11:0] cfg_addr,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        out_valid,
    input logic        out_hit,
    input logic [4:0]  out_win,
    input logic [31:0] out_addr,
    input logic [31:0] en_mask
);

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && !out_hit));

    a_r6_low_addr_misses: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_addr[31:28] != 4'hF)) |=> !out_hit);

    a_r4_index_bits: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_win == $past(req_addr[27:23])));

    a_r8_forward_addr: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_addr == (out_hit ? $past(req_addr) : 32'h0)));

    a_r3_other_offset_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_addr != 12'h060)) |=> $stable(en_mask));

    a_r10_zero_mask_no_hit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (en_mask == 32'h0)) |=> !out_hit);

    a_r5_hit_uses_mask: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_addr[31:28] == 4'hF) && en_mask[req_addr[27:23]]) |=> out_hit);

endmodule

bind mmio_window_decoder mmio_window_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_win   (out_win),
    .out_addr  (out_addr),
    .en_mask   (en_mask)
);

// File: tb/test_mmio_window_decoder.sv
module test_mmio_window_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic [4:0]  out_win;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] cur_mask = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mmio_window_decoder i_mmio_window_decoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win),
        .out_addr(out_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 12'h060) cur_mask = d;
    endtask

    task automatic probe_with(input logic [31:0] a, input logic [31:0] m);
        logic exp_hit;
        exp_hit = (a[31:28] == 4'hF) && m[a[27:23]];
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid == 1'b1, "R7 valid", {31'b0, out_valid}, 32'h1);
        check(out_hit == exp_hit, "R5 hit", {31'b0, out_hit}, {31'b0, exp_hit});
        check(out_win == a[27:23], "R4 index", {27'b0, out_win}, {27'b0, a[27:23]});
        check(out_addr == (exp_hit ? a : 32'h0), "R8 fwd", out_addr, exp_hit ? a : 32'h0);
    endtask

    task automatic probe(input logic [31:0] a);
        probe_with(a, cur_mask);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] masks [5];
        masks[0] = 32'h0000_0000; masks[1] = 32'h5555_5555; masks[2] = 32'hFFFF_FFFF;
        masks[3] = 32'h0000_0F00; masks[4] = 32'h8000_0001;

        repeat (4) @(negedge clk);
        // R1: outputs zero during reset
        check({out_valid, out_hit, out_win, out_addr} == '0, "R1 in reset",
              out_addr, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check({out_valid, out_hit, out_win, out_addr} == '0, "R1 after reset",
              out_addr, 32'h0);
        // R1 / R10: reset mask opens nothing
        probe(32'hF000_0000);
        check(out_hit == 1'b0, "R10 reset mask", {31'b0, out_hit}, 32'h0);

        // R3: writes elsewhere ignored
        wr(12'h064, 32'hFFFF_FFFF);
        wr(12'h020, 32'hFFFF_FFFF);
        probe(32'hF000_0000);
        check(out_hit == 1'b0, "R3 other offset", {31'b0, out_hit}, 32'h0);
        probe(32'hFF80_0000);
        check(out_hit == 1'b0, "R3 other offset top", {31'b0, out_hit}, 32'h0);

        // R4/R5/R6/R8/R10 sweeps
        for (int mi = 0; mi < 5; mi++) begin
            wr(12'h060, masks[mi]);
            for (int k = 0; k < 32; k++) begin
                probe(32'hF000_0000 | (k << 23));
                probe((32'hF000_0000 | (k << 23)) + 32'h7F_FFFF);
            end
            probe(32'hEFFF_FFFF);
            check(out_hit == 1'b0, "R6 below aperture", {31'b0, out_hit}, 32'h0);
            probe(32'h7F80_0000);
            check(out_hit == 1'b0, "R6 low half", {31'b0, out_hit}, 32'h0);
            probe(32'h0000_0000);
        end

        // R9: adjacent windows 8..11 form one range
        wr(12'h060, 32'h0000_0F00);
        probe(32'hF000_0000 | (9 << 23) - 1);
        check(out_hit == 1'b1, "R9 end of 8", {31'b0, out_hit}, 32'h1);
        probe(32'hF000_0000 | (9 << 23));
        check(out_hit == 1'b1, "R9 start of 9", {31'b0, out_hit}, 32'h1);
        probe(32'hF000_0000 | (12 << 23));
        check(out_hit == 1'b0, "R9 past run", {31'b0, out_hit}, 32'h0);

        // R2: write and request on the same edge use old mask
        cfg_we = 1'b1; cfg_addr = 12'h060; cfg_wdata = 32'h0000_0001;
        req_valid = 1'b1; req_addr = 32'hF000_0000;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check(out_hit == 1'b0, "R2 same edge old mask", {31'b0, out_hit}, 32'h0);
        cur_mask = 32'h0000_0001;
        probe(32'hF000_0000);
        check(out_hit == 1'b1, "R2 next edge new mask", {31'b0, out_hit}, 32'h1);

        // R7: idle cycle
        @(negedge clk);
        check(out_valid == 1'b0 && out_hit == 1'b0, "R7 idle",
              {30'b0, out_valid, out_hit}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule